// File: doc/BRIEF.md
# Multiplexed Host Port Write Controller

This block is the write side of a 16-bit multiplexed host port. An external host uses it to reach a 32-bit internal memory. The host presents a halfword on its data bus and picks a target with a 2-bit select: the control register, the address register, or the data port. The data port has two modes, one with and one without address autoincrement. A 32-bit word always arrives as two halfword strobes. An identify line tells the block whether a strobe carries the first or the second halfword. The block answers with a single busy line, and the host must not strobe while that line is high.

Internally the block keeps a 16-bit control register, a 32-bit address register and an eight-entry write FIFO. Autoincrement writes are queued in the FIFO and drained to memory through a request/acknowledge port. A fixed-address write bypasses the queue. It goes to memory once everything queued ahead of it has been written, and the host is held busy until memory accepts it. A new address waits until the FIFO is empty before it takes effect, so queued words keep the addresses they were given. The busy line rises only on particular strobes. Which strobes those are depends on the select code, the halfword position and the fill level of the FIFO.

Top module: `host_mux_write_port`

## Requirements
- R1: A write strobe is accepted when chip select is low, the data strobe is low, the read/write line is low (write) and busy is low. The select code then chooses the target: 2'b00 the control register, 2'b10 the address register, 2'b11 data without autoincrement, 2'b01 data with autoincrement.
- R2: For data and address writes, the strobe with the identify line low supplies bits 31:16 and the strobe with it high supplies bits 15:0. A word or address is acted on only when its second halfword arrives.
- R3: An accepted control-register write never raises busy.
- R4: A control-register write takes effect from one strobe, whatever the level of the identify line, and its value appears on `ctrlValue` one clock later.
- R5: On a data write without autoincrement, the first halfword leaves busy low. The second halfword raises busy on the next clock. Busy stays high until memory acknowledges the word, which is written to the current address, and the address register does not change.
- R6: Autoincrement words written after an address load into an empty FIFO leave busy low until the eighth queued word fills the FIFO.
- R7: While the FIFO is full, busy stays high and strobes are ignored. Busy falls once one entry has drained.
- R8: Each autoincrement word is queued with the current address, and the address then advances by 4. Memory writes occur in the order the host wrote them. A transfer happens on a clock where `memReq` and `memAck` are both high, and `memAddr`/`memData` stay stable while a request waits.
- R9: An address write arriving while the FIFO holds entries raises busy until the FIFO is empty, then loads the new address. If the FIFO is already empty, the address loads at once and busy stays low.
- R10: Strobes with chip select high, or with the read/write line high (read), change nothing.
- R11: While the address strobe is high, the select, identify and read/write values captured on the last clock with the address strobe low are used in place of the live lines.
- R12: After reset, busy and `memReq` are low and `ctrlValue` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostData | input | 16 | Host halfword data |
| hostSel | input | 2 | Target select code |
| hostHalf | input | 1 | Halfword identify: 0 first, 1 second |
| hostRdWr | input | 1 | 1 read, 0 write |
| hostCsN | input | 1 | Chip select, active low |
| hostAsN | input | 1 | Address strobe, active low; latches control lines |
| hostStrbN | input | 1 | Data strobe, active low, one clock per access |
| hostBusy | output | 1 | High when the host must wait |
| ctrlValue | output | 16 | Current control register contents |
| memReq | output | 1 | Memory write request |
| memAddr | output | 32 | Memory byte address |
| memData | output | 32 | Memory write word |
| memAck | input | 1 | Memory accepts the request this clock |

## Verification
A corrupted halfword holding register or a swapped halfword order shows up as a wrong `memData` on the very next memory transfer. A FIFO pointer or counter fault shows up as a missing, repeated or misaddressed write, or as busy rising one word early or late during the eight-word fill. A stuck control state leaves busy high after the acknowledge or the drain that should release it. The host then cannot make progress, and the next host access stalls within a few clocks.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA_FIX = 2'b11
  } hostSel_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic ctrlWr;       // load control register from host data
    logic addrHoldWr;   // capture upper address halfword
    logic addrNow;      // load address from hold + live halfword
    logic addrStage;    // park full address until FIFO drains
    logic addrLoad;     // load parked address
    logic dataHoldWr;   // capture upper data halfword
    logic push;         // queue word at current address, then step
    logic directStage;  // capture a fixed-address word
    logic directActive; // fixed-address word waiting for memory
  } dpStrobes_t;

  // Datapath -> control status
  typedef struct packed {
    logic fifoEmpty;
    logic fifoFull;
    logic directDone;
  } dpStatus_t;

endpackage

// File: rtl/hwp_fifo.sv
module hwp_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the controller never queues into a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  // R8: a drain happens only from a non-empty FIFO
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/hwp_ctrl.sv
module hwp_ctrl
  import hwp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostSel,
  input  logic       hostHalf,
  input  logic       hostRdWr,
  input  logic       hostCsN,
  input  logic       hostAsN,
  input  logic       hostStrbN,
  input  dpStatus_t  status,
  output dpStrobes_t strobes,
  output logic       hostBusy
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIRECT, ST_ADDR_WAIT} ctlState_e;

  ctlState_e state, nextState;
  logic [3:0] ctlLatch;
  hostSel_e  effSel;
  logic      effHalf, effRd, accept;

  // Control lines captured while the address strobe is low
  always_ff @(posedge clk) begin
    if (!rstN)         ctlLatch <= '0;
    else if (!hostAsN) ctlLatch <= {hostSel, hostHalf, hostRdWr};
  end

  always_comb begin
    if (hostAsN) begin
      effSel  = hostSel_e'(ctlLatch[3:2]);
      effHalf = ctlLatch[1];
      effRd   = ctlLatch[0];
    end else begin
      effSel  = hostSel_e'(hostSel);
      effHalf = hostHalf;
      effRd   = hostRdWr;
    end
  end

  assign hostBusy = (state != ST_IDLE) || status.fifoFull;
  assign accept   = !hostCsN && !hostStrbN && !effRd && !hostBusy;

  always_comb begin
    strobes   = '0;
    nextState = state;
    strobes.directActive = (state == ST_DIRECT);
    case (state)
      ST_IDLE: begin
        if (accept) begin
          case (effSel)
            SEL_CTRL: strobes.ctrlWr = 1'b1;
            SEL_ADDR: begin
              if (!effHalf)              strobes.addrHoldWr = 1'b1;
              else if (status.fifoEmpty) strobes.addrNow    = 1'b1;
              else begin
                strobes.addrStage = 1'b1;
                nextState         = ST_ADDR_WAIT;
              end
            end
            SEL_DATA_FIX: begin
              if (!effHalf) strobes.dataHoldWr = 1'b1;
              else begin
                strobes.directStage = 1'b1;
                nextState           = ST_DIRECT;
              end
            end
            SEL_DATA_INC: begin
              if (!effHalf) strobes.dataHoldWr = 1'b1;
              else          strobes.push       = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_DIRECT: begin
        if (status.directDone) nextState = ST_IDLE;
      end
      ST_ADDR_WAIT: begin
        if (status.fifoEmpty) begin
          strobes.addrLoad = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R1: at most one datapath action per clock
  p_single_action_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ctrlWr, strobes.addrHoldWr, strobes.addrNow, strobes.addrStage,
              strobes.addrLoad, strobes.dataHoldWr, strobes.push, strobes.directStage}));
  // R3: control writes never make the host wait
  p_ctrl_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effSel == SEL_CTRL) |=> !hostBusy);
  // R5: first data halfword completes without wait
  p_first_half_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (effSel == SEL_DATA_FIX || effSel == SEL_DATA_INC) && !effHalf) |=> !hostBusy);
  // R5: second fixed-address halfword makes the host wait
  p_second_half_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effSel == SEL_DATA_FIX && effHalf) |=> hostBusy);
  p_direct_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIRECT && !status.directDone) |=> hostBusy);
  // R9: a parked address keeps the host waiting until the drain completes
  p_addr_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_WAIT && !status.fifoEmpty) |=> hostBusy);

endmodule

// File: rtl/hwp_datapath.sv
module hwp_datapath
  import hwp_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HALF_W-1:0]   hostData,
  input  dpStrobes_t          strobes,
  output dpStatus_t           status,
  output logic [HALF_W-1:0]   ctrlValue,
  output logic                memReq,
  output logic [2*HALF_W-1:0] memAddr,
  output logic [2*HALF_W-1:0] memData,
  input  logic                memAck
);
  localparam int WORD_W  = 2 * HALF_W;
  localparam int ADDR_W  = WORD_W;
  localparam int STEP    = WORD_W / 8;
  localparam int ENTRY_W = ADDR_W + WORD_W;

  logic [HALF_W-1:0]  ctrlReg, addrHold, dataHold;
  logic [ADDR_W-1:0]  addrReg, pendAddr;
  logic [WORD_W-1:0]  directWord;
  logic [ENTRY_W-1:0] headEntry;
  logic               fifoEmpty, fifoFull, pop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      addrHold   <= '0;
      dataHold   <= '0;
      addrReg    <= '0;
      pendAddr   <= '0;
      directWord <= '0;
    end else begin
      if (strobes.ctrlWr)      ctrlReg    <= hostData;
      if (strobes.addrHoldWr)  addrHold   <= hostData;
      if (strobes.dataHoldWr)  dataHold   <= hostData;
      if (strobes.addrStage)   pendAddr   <= {addrHold, hostData};
      if (strobes.directStage) directWord <= {dataHold, hostData};
      if (strobes.addrNow)       addrReg <= {addrHold, hostData};
      else if (strobes.addrLoad) addrReg <= pendAddr;
      else if (strobes.push)     addrReg <= addrReg + ADDR_W'(STEP);
    end
  end

  hwp_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.push),
    .pushData ({addrReg, dataHold, hostData}),
    .pop      (pop),
    .headData (headEntry),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  // Queued words go first; a fixed-address word follows once the queue is empty
  assign pop     = !fifoEmpty && memAck;
  assign memReq  = !fifoEmpty || strobes.directActive;
  assign memAddr = fifoEmpty ? addrReg    : headEntry[ENTRY_W-1:WORD_W];
  assign memData = fifoEmpty ? directWord : headEntry[WORD_W-1:0];

  assign status.fifoEmpty  = fifoEmpty;
  assign status.fifoFull   = fifoFull;
  assign status.directDone = strobes.directActive && fifoEmpty && memAck;
  assign ctrlValue         = ctrlReg;

  // R8: address steps by one word after each queued word
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> addrReg == $past(addrReg) + ADDR_W'(STEP));
  // R8: a waiting request holds its address and data
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memData)));
  // R5: fixed-address writes leave the address register alone
  p_addr_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.directActive && $past(strobes.directActive)) |-> $stable(addrReg));

endmodule

// File: rtl/host_mux_write_port.sv
module host_mux_write_port
  import hwp_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HALF_W-1:0]   hostData,
  input  logic [1:0]          hostSel,
  input  logic                hostHalf,
  input  logic                hostRdWr,
  input  logic                hostCsN,
  input  logic                hostAsN,
  input  logic                hostStrbN,
  output logic                hostBusy,
  output logic [HALF_W-1:0]   ctrlValue,
  output logic                memReq,
  output logic [2*HALF_W-1:0] memAddr,
  output logic [2*HALF_W-1:0] memData,
  input  logic                memAck
);
  dpStrobes_t strobes;
  dpStatus_t  status;

  hwp_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostHalf  (hostHalf),
    .hostRdWr  (hostRdWr),
    .hostCsN   (hostCsN),
    .hostAsN   (hostAsN),
    .hostStrbN (hostStrbN),
    .status    (status),
    .strobes   (strobes),
    .hostBusy  (hostBusy)
  );

  hwp_datapath #(.HALF_W(HALF_W), .DEPTH(DEPTH)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .hostData  (hostData),
    .strobes   (strobes),
    .status    (status),
    .ctrlValue (ctrlValue),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .memData   (memData),
    .memAck    (memAck)
  );

endmodule

// File: tb/test_host_mux_write_port.sv
`timescale 1ns/1ps
module test_host_mux_write_port;
  localparam int HALF_W = 16;
  localparam int DEPTH  = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] hostData;
  logic [1:0]  hostSel;
  logic        hostHalf, hostRdWr, hostCsN, hostAsN, hostStrbN;
  logic        hostBusy;
  logic [15:0] ctrlValue;
  logic        memReq;
  logic [31:0] memAddr, memData;
  logic        memAck = 1'b0;

  always #2 clk = ~clk;

  host_mux_write_port #(.HALF_W(HALF_W), .DEPTH(DEPTH)) i_host_mux_write_port (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostSel(hostSel), .hostHalf(hostHalf),
    .hostRdWr(hostRdWr), .hostCsN(hostCsN), .hostAsN(hostAsN), .hostStrbN(hostStrbN),
    .hostBusy(hostBusy), .ctrlValue(ctrlValue), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memAck(memAck));

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit ackEn  = 1'b0;
  int ackPct = 100;
  int cycles = 0;
  logic [63:0] expQ[$];
  logic [31:0] modelAddr = '0;
  logic [15:0] modelCtrl = '0;

  function automatic void chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Memory side: random acknowledge, driven away from the active edge
  always @(negedge clk) memAck = ackEn && ($urandom_range(99) < ackPct);

  // Scoreboard of memory transfers (R8, R2)
  always @(posedge clk) begin
    if (rstN && memReq && memAck) begin
      if (expQ.size() == 0) chk("R8", "unexpected memory write", {memAddr, memData}, 64'hx);
      else chk("R8", "memory write addr/data", {memAddr, memData}, expQ.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitReady();
    while (hostBusy) @(negedge clk);
  endtask

  task automatic strobe(logic [1:0] sel, logic half, logic rd, logic csN, logic [15:0] data);
    hostSel = sel; hostHalf = half; hostRdWr = rd; hostCsN = csN;
    hostAsN = 1'b0; hostData = data; hostStrbN = 1'b0;
    @(negedge clk);
    hostStrbN = 1'b1; hostCsN = 1'b1; hostRdWr = 1'b0;
  endtask

  task automatic hostWrite(logic [1:0] sel, logic half, logic [15:0] data);
    waitReady();
    strobe(sel, half, 1'b0, 1'b0, data);
  endtask

  task automatic writeCtrl(logic half, logic [15:0] val);
    hostWrite(2'b00, half, val);
    modelCtrl = val;
    chk("R3", "busy after control write", hostBusy, 0);
    chk("R4", "control value", ctrlValue, val);
  endtask

  task automatic writeAddr(logic [31:0] a, output logic busyAfter);
    hostWrite(2'b10, 1'b0, a[31:16]);
    hostWrite(2'b10, 1'b1, a[15:0]);
    busyAfter = hostBusy;
    modelAddr = a;
  endtask

  task automatic writeWord(bit inc, logic [31:0] w, output logic busyFirst, output logic busyLast);
    hostWrite(inc ? 2'b01 : 2'b11, 1'b0, w[31:16]);
    busyFirst = hostBusy;
    hostWrite(inc ? 2'b01 : 2'b11, 1'b1, w[15:0]);
    busyLast = hostBusy;
    expQ.push_back({modelAddr, w});
    if (inc) modelAddr = modelAddr + 32'd4;
  endtask

  task automatic drain();
    ackEn = 1'b1;
    while (memReq || hostBusy) @(negedge clk);
    chk("R8", "all expected writes seen", expQ.size(), 0);
  endtask

  initial begin
    logic b0, b1;
    rstN = 1'b0; hostData = '0; hostSel = '0; hostHalf = 1'b0; hostRdWr = 1'b0;
    hostCsN = 1'b1; hostAsN = 1'b0; hostStrbN = 1'b1;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12", "busy after reset", hostBusy, 0);
    chk("R12", "memReq after reset", memReq, 0);
    chk("R12", "ctrlValue after reset", ctrlValue, 0);

    // R1/R3/R4 control writes with either identify level
    writeCtrl(1'b0, 16'hA5C3);
    writeCtrl(1'b1, 16'h1E2F);

    // R10 ignored strobes
    strobe(2'b00, 1'b0, 1'b0, 1'b1, 16'hDEAD);
    chk("R10", "chip select high ignored", ctrlValue, modelCtrl);
    strobe(2'b00, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    chk("R10", "read strobe ignored", ctrlValue, modelCtrl);
    chk("R10", "no memory request", memReq, 0);

    // R11 latched control lines
    hostAsN = 1'b0; hostSel = 2'b00; hostHalf = 1'b0; hostRdWr = 1'b0;
    @(negedge clk);
    hostAsN = 1'b1; hostSel = 2'b11; hostHalf = 1'b1; hostRdWr = 1'b1;
    hostCsN = 1'b0; hostData = 16'h7777; hostStrbN = 1'b0;
    @(negedge clk);
    hostStrbN = 1'b1; hostCsN = 1'b1; hostAsN = 1'b0; hostRdWr = 1'b0;
    modelCtrl = 16'h7777;
    chk("R11", "latched select used", ctrlValue, 16'h7777);
    chk("R11", "no busy from latched control write", hostBusy, 0);

    // R5 fixed-address write held until acknowledge
    ackEn = 1'b0;
    writeAddr(32'h0000_1000, b0);
    chk("R9", "address load into empty FIFO not busy", b0, 0);
    writeWord(1'b0, 32'hCAFE_F00D, b0, b1);
    chk("R5", "first halfword not busy", b0, 0);
    chk("R5", "second halfword busy", b1, 1);
    repeat (5) @(negedge clk);
    chk("R5", "busy held without ack", hostBusy, 1);
    chk("R2", "direct word assembled", {memAddr, memData}, {32'h0000_1000, 32'hCAFE_F00D});
    drain();
    writeWord(1'b0, 32'h0102_0304, b0, b1);
    drain();
    chk("R5", "busy released after ack", hostBusy, 0);

    // R6/R7 fill to full with no ack
    ackEn = 1'b0;
    writeAddr(32'h0000_2000, b0);
    for (int i = 0; i < DEPTH; i++) begin
      writeWord(1'b1, 32'h5500_0000 + i, b0, b1);
      chk("R6", "first halfword of queued word", b0, 0);
      chk(i < DEPTH - 1 ? "R6" : "R7", "busy after queued word", b1, (i == DEPTH - 1) ? 1 : 0);
    end
    strobe(2'b00, 1'b0, 1'b0, 1'b0, 16'h9999);
    chk("R7", "strobe while full ignored", ctrlValue, modelCtrl);
    repeat (3) @(negedge clk);
    chk("R7", "busy held while full", hostBusy, 1);
    ackPct = 100; ackEn = 1'b1;
    for (int i = 0; i < 10 && hostBusy; i++) @(negedge clk);
    chk("R7", "busy drops after one drain", hostBusy, 0);
    drain();

    // R9 address write while FIFO holds entries
    ackEn = 1'b0;
    writeAddr(32'h0000_3000, b0);
    for (int i = 0; i < 3; i++) writeWord(1'b1, 32'h3300_0000 + i, b0, b1);
    writeAddr(32'h0000_4000, b0);
    chk("R9", "address write busy while FIFO holds words", b0, 1);
    repeat (4) @(negedge clk);
    chk("R9", "busy held until drained", hostBusy, 1);
    ackEn = 1'b1;
    writeWord(1'b1, 32'h4400_0001, b0, b1);
    drain();

    // Random phase (R1-R10)
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(5);
      ackPct = 30 + $urandom_range(70);
      ackEn = 1'b1;
      case (op)
        0: writeCtrl(1'($urandom_range(1)), 16'($urandom));
        1: begin
          writeAddr({$urandom(), 2'b00} >> 2 << 2, b0);
        end
        2: begin
          writeWord(1'b0, $urandom(), b0, b1);
          chk("R5", "random fixed first half not busy", b0, 0);
          chk("R5", "random fixed second half busy", b1, 1);
        end
        5: begin
          waitReady();
          strobe(2'b00, 1'b0, 1'($urandom_range(1)), 1'b1, 16'($urandom));
          chk("R10", "random ignored strobe", ctrlValue, modelCtrl);
        end
        default: begin
          writeWord(1'b1, $urandom(), b0, b1);
          chk("R6", "random queued first half not busy", b0, 0);
        end
      endcase
    end
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule